// File: doc/BRIEF.md
# Program Counter Unit with Two-Entry Return Stack

This block holds the program counter of a small 8-bit core that uses a 9-bit PC. Each cycle it receives one control command from the decoder, along with the immediate address bits of the current instruction and an 8-bit data value. The command is one of: increment, absolute jump, subroutine call, subroutine return, write to the PC low byte, or reset. On the next clock edge it produces the new PC and the fetch address that goes to the instruction memory.

The return stack is a fixed two-entry shift register. A call pushes the address that follows the call, and the older entry moves down. A return pops the newest entry, and the oldest entry stays in place. As a result, a third nested call silently loses the oldest return address, and extra returns keep reloading the address held in the bottom entry. Calls and writes to the PC low byte can only reach the lower 256 words, because they always clear PC bit 8.

After reset the PC points at the last implemented word, so the first increment rolls it over to word 0. The implemented memory size is a parameter (256 or 512 words). The fetch address is the PC modulo that size, so an address above a 256-word memory folds back into it. Any command that redirects the PC raises a flush output in the following cycle, so that the core can discard the instruction it has already prefetched.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high, and on the edge after command code 5 (reset), the PC becomes MEM_WORDS-1, both stack entries become 0, and `flush` is low in the following cycle.
- R2: Command code 0 (increment) sets the PC to PC+1 modulo 512, so 0x1FF is followed by 0x000.
- R3: Command code 1 (jump) loads all 9 bits of `imm_addr` into the PC.
- R4: Command code 2 (call) loads PC[7:0] from `imm_addr[7:0]` and clears PC[8]. It moves stack entry 1 into entry 2 and stores PC+1 (modulo 512) in entry 1.
- R5: Command code 4 (low-byte write) loads PC[7:0] from `wr_data` and clears PC[8].
- R6: Command code 3 (return) loads entry 1 into the PC and copies entry 2 into entry 1, leaving entry 2 unchanged. Repeated returns therefore keep yielding the entry-2 address.
- R7: After three or more nested calls, returns yield only the two most recent return addresses, with no overflow or underflow indication.
- R8: `fetch_addr` equals the PC modulo MEM_WORDS, so with 256 words, PC 0x100 to 0x1FF fetch words 0x00 to 0xFF.
- R9: `flush` is high for exactly the cycle after a jump, call, return or low-byte write, and low in the cycle after any other command.
- R10: Command codes 6 and 7 behave exactly like increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 increment, 1 jump, 2 call, 3 return, 4 low-byte write, 5 reset, 6/7 increment |
| imm_addr | input | 9 | Address field of the instruction (jump uses 9 bits, call uses the low 8) |
| wr_data | input | 8 | Data value for a write to the PC low byte |
| pc_out | output | 9 | Current program counter |
| fetch_addr | output | $clog2(MEM_WORDS) | PC modulo the implemented memory size |
| flush | output | 1 | Discard the prefetched instruction in this cycle |

## Verification
Both stack entries are hidden, so a wrong stack state becomes visible only at a later return. The bench therefore runs call chains of depth one to four, then runs one more return than there were calls, so that every entry and the entry-2 duplication each reach `pc_out` within a few cycles. A wrong PC load or a wrongly kept bit 8 shows on `pc_out` in the very next cycle. A wrong wrap shows on `fetch_addr` in that same cycle. The bench runs both memory sizes side by side, so that the folding of the upper half is compared against the full-range behaviour.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W  = 9;
    localparam int LO_W  = 8;
    localparam int CMD_W = 3;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_INC  = 3'd0,
        CMD_JUMP = 3'd1,
        CMD_CALL = 3'd2,
        CMD_RET  = 3'd3,
        CMD_WRLO = 3'd4,
        CMD_RST  = 3'd5
    } pc_cmd_e;

    typedef struct packed {
        pc_t  next_pc;
        pc_t  ret_addr;
        logic push;
        logic pop;
        logic clr;
        logic redirect;
    } pc_ctl_t;

    // Place an 8-bit value in the lower page (bit 8 forced to zero)
    function automatic pc_t page0(input logic [LO_W-1:0] lo);
        return {{(PC_W-LO_W){1'b0}}, lo};
    endfunction

    function automatic pc_t pc_inc(input pc_t p);
        return p + pc_t'(1);
    endfunction

endpackage

// File: rtl/pcu_next_calc.sv
module pcu_next_calc
    import pcu_pkg::*;
#(
    parameter pc_t RESET_PC = '1
)(
    input  pc_t                 pc_q,
    input  logic [CMD_W-1:0]    cmd,
    input  pc_t                 imm,
    input  logic [LO_W-1:0]     data,
    input  pc_t                 stack_top,
    output pc_ctl_t             ctl
);

    always_comb begin
        ctl          = '0;
        ctl.next_pc  = pc_inc(pc_q);
        ctl.ret_addr = pc_inc(pc_q);
        case (cmd)
            CMD_JUMP: begin
                ctl.next_pc  = imm;
                ctl.redirect = 1'b1;
            end
            CMD_CALL: begin
                ctl.next_pc  = page0(imm[LO_W-1:0]);
                ctl.push     = 1'b1;
                ctl.redirect = 1'b1;
            end
            CMD_RET: begin
                ctl.next_pc  = stack_top;
                ctl.pop      = 1'b1;
                ctl.redirect = 1'b1;
            end
            CMD_WRLO: begin
                ctl.next_pc  = page0(data);
                ctl.redirect = 1'b1;
            end
            CMD_RST: begin
                ctl.next_pc  = RESET_PC;
                ctl.clr      = 1'b1;
            end
            default: ;  // increment, including the spare codes
        endcase
    end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack
    import pcu_pkg::*;
#(
    parameter int DEPTH = 2
)(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic push,
    input  logic pop,
    input  pc_t  push_val,
    output pc_t  top
);

    pc_t lvl      [DEPTH];
    pc_t push_src [DEPTH];
    pc_t pop_src  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        if (i == 0) begin : g_head
            assign push_src[i] = push_val;
        end else begin : g_body
            assign push_src[i] = lvl[i-1];
        end

        if (i == DEPTH-1) begin : g_tail
            assign pop_src[i] = lvl[i];     // bottom entry keeps its value
        end else begin : g_mid
            assign pop_src[i] = lvl[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                lvl[i] <= '0;
            end else if (push) begin
                lvl[i] <= push_src[i];
            end else if (pop) begin
                lvl[i] <= pop_src[i];
            end
        end
    end

    assign top = lvl[0];

endmodule

// File: rtl/pcu_flush_gen.sv
module pcu_flush_gen (
    input  logic clk,
    input  logic rst,
    input  logic redirect,
    output logic flush
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush <= 1'b0;
        end else begin
            flush <= redirect;
        end
    end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter  int MEM_WORDS   = 512,
    parameter  int STACK_DEPTH = 2,
    localparam int AW          = $clog2(MEM_WORDS)
)(
    input  logic                clk,
    input  logic                rst,
    input  logic [CMD_W-1:0]    cmd,
    input  logic [PC_W-1:0]     imm_addr,
    input  logic [LO_W-1:0]     wr_data,
    output logic [PC_W-1:0]     pc_out,
    output logic [AW-1:0]       fetch_addr,
    output logic                flush
);

    localparam pc_t RESET_PC = pc_t'(MEM_WORDS - 1);

    pc_t     pc_q;
    pc_t     stack_top;
    pc_ctl_t ctl;

    pcu_next_calc #(
        .RESET_PC (RESET_PC)
    ) u_next (
        .pc_q      (pc_q),
        .cmd       (cmd),
        .imm       (imm_addr),
        .data      (wr_data),
        .stack_top (stack_top),
        .ctl       (ctl)
    );

    pcu_ret_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .push_val (ctl.ret_addr),
        .top      (stack_top)
    );

    pcu_flush_gen u_flush (
        .clk      (clk),
        .rst      (rst),
        .redirect (ctl.redirect),
        .flush    (flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= ctl.next_pc;
        end
    end

    assign pc_out = pc_q;

    // Fold the PC into the implemented memory
    if (AW >= PC_W) begin : g_full
        assign fetch_addr = AW'(pc_q);
    end else begin : g_fold
        assign fetch_addr = pc_q[AW-1:0];
    end

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
    import pcu_pkg::*;
#(
    parameter  int MEM_WORDS = 512,
    localparam int AW        = $clog2(MEM_WORDS)
)(
    input logic                clk,
    input logic                rst,
    input logic [CMD_W-1:0]    cmd,
    input logic [PC_W-1:0]     imm_addr,
    input logic [LO_W-1:0]     wr_data,
    input logic [PC_W-1:0]     pc_out,
    input logic [AW-1:0]       fetch_addr,
    input logic                flush
);

    localparam pc_t LAST = pc_t'(MEM_WORDS - 1);

    logic redir_cmd;
    assign redir_cmd = (cmd == CMD_JUMP) || (cmd == CMD_CALL) ||
                       (cmd == CMD_RET)  || (cmd == CMD_WRLO);

    AST_RESET_LAST: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RST) |=> (pc_out == LAST) && !flush);  // R1

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INC) |=> pc_out == PC_W'($past(pc_out) + PC_W'(1)));  // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_JUMP) |=> pc_out == $past(imm_addr));  // R3

    AST_CALL_PAGE0: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CALL) |=> (pc_out[PC_W-1] == 1'b0) &&
                              (pc_out[LO_W-1:0] == $past(imm_addr[LO_W-1:0])));  // R4

    AST_WRLO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_WRLO) |=> pc_out == {1'b0, $past(wr_data)});  // R5

    AST_RET_AFTER_CALL: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RET) && ($past(cmd) == CMD_CALL) && !$past(rst))
        |=> pc_out == PC_W'($past(pc_out, 2) + PC_W'(1)));  // R6

    AST_FETCH_FOLD: assert property (@(posedge clk) disable iff (rst)
        int'(fetch_addr) == (int'(pc_out) % MEM_WORDS));  // R8

    AST_FLUSH_SET: assert property (@(posedge clk) disable iff (rst)
        redir_cmd |=> flush);  // R9

    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !redir_cmd |=> !flush);  // R9

endmodule

bind pcu_top pcu_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .imm_addr   (imm_addr),
    .wr_data    (wr_data),
    .pc_out     (pc_out),
    .fetch_addr (fetch_addr),
    .flush      (flush)
);

// File: tb/pcu_top_tb.sv
`timescale 1ns/1ps
module pcu_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [8:0] imm = '0;
    logic [7:0] wd  = '0;

    logic [8:0] pc_a, fa_a;
    logic       fl_a;
    logic [8:0] pc_b;
    logic [7:0] fa_b;
    logic       fl_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int mpc [2];
    int ms1 [2];
    int ms2 [2];
    int mem [2] = '{512, 256};

    always #10 clk = ~clk;

    pcu_top #(.MEM_WORDS(512)) u_dut (
        .clk(clk), .rst(rst), .cmd(cmd), .imm_addr(imm), .wr_data(wd),
        .pc_out(pc_a), .fetch_addr(fa_a), .flush(fl_a));

    pcu_top #(.MEM_WORDS(256)) u_dut_half (
        .clk(clk), .rst(rst), .cmd(cmd), .imm_addr(imm), .wr_data(wd),
        .pc_out(pc_b), .fetch_addr(fa_b), .flush(fl_b));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input bit exp_fl);
        chk(int'(pc_a) == mpc[0], req, "pc (512)", int'(pc_a), mpc[0]);
        chk(int'(pc_b) == mpc[1], req, "pc (256)", int'(pc_b), mpc[1]);
        chk(int'(fa_a) == mpc[0] % mem[0], "R8", "fetch (512)", int'(fa_a), mpc[0] % mem[0]);
        chk(int'(fa_b) == mpc[1] % mem[1], "R8", "fetch (256)", int'(fa_b), mpc[1] % mem[1]);
        chk(fl_a == exp_fl, "R9", "flush (512)", int'(fl_a), int'(exp_fl));
        chk(fl_b == exp_fl, "R9", "flush (256)", int'(fl_b), int'(exp_fl));
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            mpc[k] = mem[k] - 1;
            ms1[k] = 0;
            ms2[k] = 0;
        end
    endtask

    task automatic pin_reset();
        rst = 1'b1;
        cmd = 3'd0;
        @(posedge clk); #2;
        rst = 1'b0;
        model_reset();
        check_all("R1", 1'b0);
    endtask

    task automatic step(input logic [2:0] c, input logic [8:0] im,
                        input logic [7:0] d, input string req);
        bit redir;
        cmd = c; imm = im; wd = d;
        @(posedge clk); #2;
        redir = (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
        for (int k = 0; k < 2; k++) begin
            case (c)
                3'd1: mpc[k] = int'(im);
                3'd2: begin
                    ms2[k] = ms1[k];
                    ms1[k] = (mpc[k] + 1) % 512;
                    mpc[k] = int'(im) % 256;
                end
                3'd3: begin
                    mpc[k] = ms1[k];
                    ms1[k] = ms2[k];
                end
                3'd4: mpc[k] = int'(d);
                3'd5: begin
                    mpc[k] = mem[k] - 1;
                    ms1[k] = 0;
                    ms2[k] = 0;
                end
                default: mpc[k] = (mpc[k] + 1) % 512;
            endcase
        end
        check_all(req, redir);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset to the last implemented word
        pin_reset();

        // R2 / R8: first increment rolls over, then a long increment run
        step(3'd0, 9'h000, 8'h00, "R2");
        for (int i = 0; i < 600; i++) step(3'd0, 9'h000, 8'h00, "R2");

        // R3: every jump target, each followed by an increment
        for (int a = 0; a < 512; a++) begin
            step(3'd1, 9'(a), 8'h00, "R3");
            step(3'd0, 9'h000, 8'h00, "R2");
        end

        // R5: low-byte write from the upper page clears bit 8
        for (int v = 0; v < 256; v++) begin
            step(3'd1, 9'(9'h100 | v), 8'h00, "R3");
            step(3'd4, 9'h1FF, 8'(v ^ 8'h5A), "R5");
        end

        // R4 / R6 / R7: call chains of depth 1..4 from both pages, one extra return
        for (int b = 0; b < 16; b++) begin
            for (int depth = 1; depth <= 4; depth++) begin
                step(3'd1, 9'(b * 32 + 3), 8'h00, "R3");
                for (int c = 0; c < depth; c++) begin
                    step(3'd2, 9'(9'h100 | (b * 13 + c * 40)), 8'h00, "R4");
                    step(3'd0, 9'h000, 8'h00, "R2");
                end
                for (int r = 0; r <= depth; r++)
                    step(3'd3, 9'h000, 8'h00, depth > 2 ? "R7" : "R6");
            end
        end

        // R10: spare codes increment
        step(3'd1, 9'h1FE, 8'h00, "R3");
        step(3'd6, 9'h0AA, 8'h55, "R10");
        step(3'd7, 9'h0AA, 8'h55, "R10");
        step(3'd6, 9'h0AA, 8'h55, "R10");

        // R1: reset command clears the stack, seen by a return afterwards
        step(3'd1, 9'h040, 8'h00, "R3");
        step(3'd2, 9'h1C3, 8'h00, "R4");
        step(3'd2, 9'h0D7, 8'h00, "R4");
        step(3'd5, 9'h000, 8'h00, "R1");
        step(3'd3, 9'h000, 8'h00, "R1");
        step(3'd0, 9'h000, 8'h00, "R2");

        // R1: pin reset in the middle of a chain
        step(3'd2, 9'h011, 8'h00, "R4");
        pin_reset();
        step(3'd3, 9'h000, 8'h00, "R1");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule